// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block passively watches the clock and data lines of a two-wire serial bus. A system clock much faster than the bus clock samples both lines. Each line passes through a two-flop synchronizer and then a majority-vote glitch filter. Edge detection on the filtered lines then yields single-cycle event pulses: one for a first START, one for a repeated START, and one for a STOP. A level output tracks whether the bus is in use.

After a STOP, the busy level is held until a bus-free interval has passed. The length of that interval is set on an input port. A START seen during that interval is a new transaction, not a repeated one. The monitor also counts clock rising edges since the most recent START, modulo 9, which gives the bit position inside the current byte including the acknowledge slot. A separate timer raises a flag when the clock line stays low longer than a programmable limit.

The monitor never drives the bus and does not decode addresses or data.

Top module: `i2c_cond_mon`

## Requirements
- R1: A data-line pulse only one system clock wide never produces an event and never changes the busy level. With the default filter length of 3, the filter passes a level only after it is held for at least 2 of the last 3 samples.
- R2: When the bus is idle, a falling data line while the clock is high gives exactly one `start_o` pulse. `busy_o` then goes to 1.
- R3: While `busy_o` is 1 and no STOP is pending, a falling data line with the clock high gives one `rstart_o` pulse and no `start_o` pulse. `busy_o` stays at 1.
- R4: A rising data line while the clock is high gives exactly one `stop_o` pulse.
- R5: After a STOP, `busy_o` stays at 1 for `free_cyc_i`+1 cycles and then falls to 0. A START that arrives inside this window is reported on `start_o`, not on `rstart_o`.
- R6: `bit_cnt_o` is cleared to 0 by every START or repeated START. It increments on each filtered clock rising edge and wraps from 8 back to 0, so it never exceeds 8.
- R7: Data-line changes made while the clock is low produce no event.
- R8: `scl_stuck_o` rises once the filtered clock has been low for more than `stuck_cyc_i` cycles. It returns to 0 one cycle after the filtered clock is high.
- R9: After reset, all event outputs are 0, `busy_o` is 0, `bit_cnt_o` is 0 and `scl_stuck_o` is 0.
- R10: START and STOP pulses last one cycle and never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| free_cyc_i | input | CNT_W | Bus-free time after STOP, in system cycles |
| stuck_cyc_i | input | CNT_W | Clock-low timeout, in system cycles |
| start_o | output | 1 | One-cycle pulse on a first START |
| rstart_o | output | 1 | One-cycle pulse on a repeated START |
| stop_o | output | 1 | One-cycle pulse on a STOP |
| busy_o | output | 1 | Bus-in-use level |
| bit_cnt_o | output | 4 | Clock rising edges since the last START, modulo 9 |
| scl_stuck_o | output | 1 | Clock held low past the timeout |

## Verification
Some properties are checked by assertions on every cycle:
- a filtered line only changes toward the value most recently shifted into its window;
- START and STOP are exclusive and last one cycle;
- every START or repeated START coincides with a busy level and a cleared bit count;
- the bit count stays within 0 to 8;
- busy falls only when the free timer has run out;
- the stuck flag rises only after a low clock and clears once the clock is high.

Other behaviours can only be shown by the bench scenarios:
- a one-cycle spike is rejected;
- a START during the bus-free window is classified as a first START;
- the count wraps after nine clock edges;
- the busy level persists for the programmed time after a STOP;
- a short low clock never raises the stuck flag.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  localparam int BIT_CNT_W = 4;
  localparam int BITS_PER_SLOT = 9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_FREE = 2'd2
  } bus_st_e;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int HALF = FILT_LEN / 2;
  localparam int CW   = $clog2(FILT_LEN + 1);

  logic                s1_q, s2_q;
  logic [FILT_LEN-1:0] win_q;
  logic                filt_q;
  logic [CW-1:0]       ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < FILT_LEN; i++) ones = ones + CW'(win_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      win_q  <= '1;
      filt_q <= 1'b1;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      win_q  <= {win_q[FILT_LEN-2:0], s2_q};
      filt_q <= (int'(ones) > HALF);
    end
  end

  assign line_o = filt_q;

  // filtered output moves only toward the newest window sample
  a_r1_follow_newest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> filt_q == $past(win_q[0]));
endmodule

// File: rtl/cond_detect.sv
module cond_detect
  import i2cmon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_f_i,
  input  logic                 sda_f_i,
  input  logic [CNT_W-1:0]     free_cyc_i,
  output logic                 start_o,
  output logic                 rstart_o,
  output logic                 stop_o,
  output logic                 busy_o,
  output logic [BIT_CNT_W-1:0] bit_cnt_o
);
  logic       scl_q, sda_q;
  logic       start_c, stop_c, scl_rise;
  bus_st_e    st_q;
  logic [CNT_W-1:0]     free_q;
  logic [BIT_CNT_W-1:0] cnt_q;

  assign start_c  = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_c   = scl_f_i & scl_q & ~sda_q & sda_f_i;
  assign scl_rise = scl_f_i & ~scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      st_q     <= ST_IDLE;
      free_q   <= '0;
      cnt_q    <= '0;
      start_o  <= 1'b0;
      rstart_o <= 1'b0;
      stop_o   <= 1'b0;
    end else begin
      scl_q    <= scl_f_i;
      sda_q    <= sda_f_i;
      start_o  <= start_c & (st_q != ST_BUSY);
      rstart_o <= start_c & (st_q == ST_BUSY);
      stop_o   <= stop_c;
      if (start_c) begin
        st_q <= ST_BUSY;
      end else if (stop_c) begin
        if (st_q != ST_IDLE) begin
          st_q   <= ST_FREE;
          free_q <= free_cyc_i;
        end
      end else if (st_q == ST_FREE) begin
        if (free_q == '0) st_q <= ST_IDLE;
        else              free_q <= free_q - 1'b1;
      end
      if (start_c)
        cnt_q <= '0;
      else if (scl_rise)
        cnt_q <= (int'(cnt_q) == BITS_PER_SLOT - 1) ? '0 : cnt_q + 1'b1;
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign bit_cnt_o = cnt_q;

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o) && !(rstart_o && stop_o));
  a_r10_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || rstart_o || stop_o) |=> !(start_o || rstart_o || stop_o));
  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o && bit_cnt_o == '0);
  a_r3_rstart_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rstart_o |-> busy_o && bit_cnt_o == '0);
  a_r6_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(bit_cnt_o) < BITS_PER_SLOT);
  a_r5_fall_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(free_q) == '0);
endmodule

// File: rtl/stuck_det.sv
module stuck_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_f_i,
  input  logic [CNT_W-1:0] stuck_cyc_i,
  output logic             stuck_o
);
  logic [CNT_W-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q   <= '0;
      stuck_o <= 1'b0;
    end else if (scl_f_i) begin
      low_q   <= '0;
      stuck_o <= 1'b0;
    end else if (low_q >= stuck_cyc_i) begin
      stuck_o <= 1'b1;
    end else begin
      low_q <= low_q + 1'b1;
    end
  end

  a_r8_clear_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_f_i |=> !stuck_o);
  a_r8_rise_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stuck_o) |-> !$past(scl_f_i));
endmodule

// File: rtl/i2c_cond_mon.sv
module i2c_cond_mon
  import i2cmon_pkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter int CNT_W    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [CNT_W-1:0]     free_cyc_i,
  input  logic [CNT_W-1:0]     stuck_cyc_i,
  output logic                 start_o,
  output logic                 rstart_o,
  output logic                 stop_o,
  output logic                 busy_o,
  output logic [BIT_CNT_W-1:0] bit_cnt_o,
  output logic                 scl_stuck_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[g]),
      .line_o (filt[g])
    );
  end

  cond_detect #(.CNT_W(CNT_W)) u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_f_i    (filt[0]),
    .sda_f_i    (filt[1]),
    .free_cyc_i (free_cyc_i),
    .start_o    (start_o),
    .rstart_o   (rstart_o),
    .stop_o     (stop_o),
    .busy_o     (busy_o),
    .bit_cnt_o  (bit_cnt_o)
  );

  stuck_det #(.CNT_W(CNT_W)) u_stuck (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_f_i     (filt[0]),
    .stuck_cyc_i (stuck_cyc_i),
    .stuck_o     (scl_stuck_o)
  );
endmodule

// File: tb/i2c_cond_mon_bench.sv
module i2c_cond_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q     = 12;
  localparam int FREE  = 40;
  localparam int STUCK = 100;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
  logic start, rstart, stop, busy, stuck;
  logic [3:0] bcnt;
  int n_start = 0, n_rstart = 0, n_stop = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cond_mon u_i2c_cond_mon (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .free_cyc_i(16'(FREE)), .stuck_cyc_i(16'(STUCK)),
    .start_o(start), .rstart_o(rstart), .stop_o(stop), .busy_o(busy),
    .bit_cnt_o(bcnt), .scl_stuck_o(stuck));

  always @(posedge clk) begin
    if (start)  n_start++;
    if (rstart) n_rstart++;
    if (stop)   n_stop++;
  end

  task automatic wt(int n); repeat (n) @(negedge clk); endtask
  task automatic clr(); wt(1); n_start = 0; n_rstart = 0; n_stop = 0; endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R9 busy", busy, 0);   chk("R9 bitcnt", bcnt, 0);
    chk("R9 stuck", stuck, 0); chk("R9 events", start | rstart | stop, 0);
  endtask

  task automatic t_spike();
    clr(); sda = 1'b0; wt(1); sda = 1'b1; wt(Q);
    chk("R1 spike start", n_start, 0); chk("R1 spike busy", busy, 0);
  endtask

  task automatic t_start();
    clr(); sda = 1'b0; wt(Q);
    chk("R2 start count", n_start, 1); chk("R2 no rstart", n_rstart, 0);
    chk("R2 busy", busy, 1);           chk("R6 cleared", bcnt, 0);
  endtask

  task automatic t_bits(int n, int exp);
    clr();
    for (int i = 0; i < n; i++) begin
      scl = 1'b0; wt(Q/2); sda = ~sda; wt(Q/2); scl = 1'b1; wt(Q);
    end
    chk("R6 bit count", bcnt, exp);
    chk("R7 no events", n_start + n_rstart + n_stop, 0);
  endtask

  task automatic t_rstart();
    clr(); scl = 1'b0; wt(Q); sda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    sda = 1'b0; wt(Q);
    chk("R3 rstart count", n_rstart, 1); chk("R3 no start", n_start, 0);
    chk("R3 busy", busy, 1);             chk("R6 cleared by Sr", bcnt, 0);
  endtask

  task automatic do_stop();
    scl = 1'b0; wt(Q); sda = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda = 1'b1;
  endtask

  task automatic t_stop();
    clr(); do_stop(); wt(Q);
    chk("R4 stop count", n_stop, 1); chk("R5 busy held", busy, 1);
    wt(FREE);
    chk("R5 busy released", busy, 0);
  endtask

  task automatic t_start_in_free();
    clr(); sda = 1'b0; wt(Q);    // fresh START from idle
    do_stop(); wt(Q);
    sda = 1'b0; wt(Q);
    chk("R5 start in window", n_start, 2); chk("R5 not rstart", n_rstart, 0);
    chk("R5 busy", busy, 1);
    do_stop(); wt(Q + FREE);
    chk("R5 idle again", busy, 0);
  endtask

  task automatic t_stuck();
    scl = 1'b0; wt(STUCK/2);
    chk("R8 short low", stuck, 0);
    wt(STUCK);
    chk("R8 long low", stuck, 1);
    scl = 1'b1; wt(Q);
    chk("R8 released", stuck, 0); chk("R8 busy idle", busy, 0);
  endtask

  initial begin
    wt(3); rst_n = 1'b1; wt(2);
    t_reset();
    t_spike();
    t_start();
    t_bits(3, 3);
    t_bits(6, 0);
    t_bits(2, 2);
    t_rstart();
    t_bits(1, 1);
    t_stop();
    t_start_in_free();
    t_stuck();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule